// File: doc/BRIEF.md
# 10BASE-T Normal Loopback Controller

This block sits in the digital section of a 10 Mb/s twisted-pair transceiver, between the MAC's serial transmit and receive pins and the decoded line receiver. While the MAC is sending, the block runs each transmitted bit through an internal Manchester encoder and decoder and returns it on the receive pins. This lets the MAC see its own frame. A collision, a jabber condition or a failed link removes the loopback, and the receive pins then carry the decoded twisted-pair data again. At the end of every transmission the block also raises a collision heartbeat pulse of fixed length.

The block runs on a clock at twice the bit rate. A phase bit, cleared by reset, marks the edges where a bit cell starts; these are the bit boundaries. The serial inputs are sampled only at boundaries. A controller with four named states picks the receive source:
- LINKDN: the link has failed, or reset has just ended. The line path is used.
- IDLE: no transmission. The line path is used.
- LOOP: loopback carries the frame.
- HOLD: loopback was refused or dropped for the current frame. The line path is used.

Transitions happen only at boundaries, in this order of priority:
- Link fail leads from any state to LINKDN.
- LINKDN goes to HOLD if the MAC is already sending, and to IDLE otherwise.
- IDLE goes to LOOP when transmit enable is seen with neither collision nor jabber. It goes to HOLD when transmit enable is seen together with either of them.
- LOOP goes to HOLD on collision or jabber. It returns to IDLE once transmit enable is low and the last looped bit has been delivered.
- HOLD goes to IDLE once transmit enable is low.

Top module: `tenbt_loopback`

## Requirements
- R1: In LOOP, the receive pins in the bit period after boundary k+1 carry the txd and tx_en values sampled at boundary k, after a Manchester round trip. The encoder sends 0 as high-then-low and 1 as low-then-high. The decoder takes the second half as the bit. line_data and line_valid have no effect in LOOP.
- R2: Loopback starts only at a boundary where tx_en is high. After tx_en goes low, the last bit is still delivered, and the next boundary returns the block to the line path.
- R3: A collision sampled at a boundary forces the line path, and the line path stays for the rest of that transmission, until tx_en is sampled low.
- R4: Link fail sampled at a boundary forces the line path. Reset enters LINKDN, and loopback cannot start before a boundary where link fail is clear.
- R5: Jabber sampled at a boundary forces the line path for the rest of that transmission, in the same way as collision.
- R6: Outside LOOP, rxd and rx_dv in each bit period equal line_data and line_valid sampled at the boundary that opened it.
- R7: rxd and rx_dv change only on boundary edges. A loss of loopback in mid-frame therefore drops rx_dv at a bit boundary, never inside a bit cell.
- R8: hb_col goes high on the clock after tx_en is first sampled low following a high, and stays high for exactly HB_LEN clock cycles. A new end of transmission restarts the count.
- R9: During and right after reset, rxd, rx_dv and hb_col are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | MAC transmit enable |
| txd | input | 1 | MAC serial transmit bit |
| line_data | input | 1 | Decoded twisted-pair receive bit |
| line_valid | input | 1 | Decoded twisted-pair data valid |
| col | input | 1 | Collision status |
| link_fail | input | 1 | Link-fail status |
| jabber | input | 1 | Jabber status |
| rxd | output | 1 | Serial receive bit to the MAC |
| rx_dv | output | 1 | Receive data valid to the MAC |
| hb_col | output | 1 | Collision heartbeat pulse |

## Verification
A wrong controller state shows up at the receive pins within one bit period. Line bits appear where echoed transmit bits were expected, or the reverse, or rx_dv stays high for a frame that should have been cut off. A wrong phase or decoder capture shifts or inverts the echoed bits, which a per-bit comparison catches at the first mismatched bit. A heartbeat counter fault changes the pulse length, which is seen only once the pulse ends.

// File: rtl/tbl_pkg.sv
package tbl_pkg;
    typedef enum logic [1:0] {
        ST_LINKDN = 2'd0,
        ST_IDLE   = 2'd1,
        ST_LOOP   = 2'd2,
        ST_HOLD   = 2'd3
    } lb_state_e;
endpackage

// File: rtl/lb_manch_enc.sv
module lb_manch_enc (
    input  logic clk,
    input  logic rst_n,
    input  logic bnd,
    input  logic txd,
    input  logic tx_en,
    output logic man_o,
    output logic vld_o
);
    logic bit_q;

    // first half carries the complement, second half the bit itself
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            man_o <= 1'b0;
            bit_q <= 1'b0;
            vld_o <= 1'b0;
        end else if (bnd) begin
            man_o <= ~txd;
            bit_q <= txd;
            vld_o <= tx_en;
        end else begin
            man_o <= bit_q;
        end
    end
endmodule

// File: rtl/lb_manch_dec.sv
module lb_manch_dec (
    input  logic clk,
    input  logic rst_n,
    input  logic bnd,
    input  logic man_i,
    input  logic vld_i,
    output logic bit_o,
    output logic vld_o
);
    logic first_q;
    logic viol_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b0;
            bit_o   <= 1'b0;
            vld_o   <= 1'b0;
            viol_q  <= 1'b0;
        end else if (!bnd) begin
            first_q <= man_i;
        end else begin
            bit_o  <= man_i;
            vld_o  <= vld_i;
            viol_q <= vld_i && (man_i == first_q);
        end
    end

    // R1: a valid looped cell always has two different halves
    p_cell_halves_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd && vld_i) |-> (man_i != first_q));
    p_no_violation_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !viol_q);
endmodule

// File: rtl/lb_mode_fsm.sv
module lb_mode_fsm
    import tbl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bnd,
    input  logic      tx_en,
    input  logic      col,
    input  logic      link_fail,
    input  logic      jabber,
    input  logic      enc_vld,
    output lb_state_e state_o,
    output logic      loop_o
);
    lb_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LINKDN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (bnd) begin
            if (link_fail) begin
                state_d = ST_LINKDN;
            end else begin
                unique case (state_q)
                    ST_LINKDN: state_d = tx_en ? ST_HOLD : ST_IDLE;
                    ST_IDLE:   if (tx_en) state_d = (col || jabber) ? ST_HOLD : ST_LOOP;
                    ST_LOOP: begin
                        if (col || jabber)          state_d = ST_HOLD;
                        else if (!tx_en && !enc_vld) state_d = ST_IDLE;
                    end
                    ST_HOLD:   if (!tx_en) state_d = ST_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        state_o = state_q;
        loop_o  = (state_q == ST_LOOP);
    end

    p_linkfail_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd && link_fail) |=> (state_q == ST_LINKDN));
    p_collision_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd && col) |=> (state_q != ST_LOOP));
    p_jabber_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd && jabber) |=> (state_q != ST_LOOP));
    p_start_on_tx_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_LOOP && !(bnd && tx_en)) |=> (state_q != ST_LOOP));
endmodule

// File: rtl/lb_heartbeat.sv
module lb_heartbeat #(
    parameter int HB_LEN = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    output logic hb_o
);
    localparam int W = $clog2(HB_LEN + 1);
    localparam logic [W-1:0] HB_LOAD = W'(HB_LEN);

    logic         tx_q;
    logic [W-1:0] cnt_q;
    logic         tx_end;

    assign tx_end = tx_q && !tx_en;
    assign hb_o   = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q  <= 1'b0;
            cnt_q <= '0;
        end else begin
            tx_q <= tx_en;
            if (tx_end)          cnt_q <= HB_LOAD;
            else if (cnt_q != '0) cnt_q <= cnt_q - W'(1);
        end
    end

    p_hb_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_end |=> hb_o);
    p_hb_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hb_o && !tx_end) |=> !hb_o);
endmodule

// File: rtl/tenbt_loopback.sv
module tenbt_loopback
    import tbl_pkg::*;
#(
    parameter int HB_LEN = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic txd,
    input  logic line_data,
    input  logic line_valid,
    input  logic col,
    input  logic link_fail,
    input  logic jabber,
    output logic rxd,
    output logic rx_dv,
    output logic hb_col
);
    logic      ph_q, bnd;
    logic      man, enc_vld, dec_bit, dec_vld;
    logic      line_bit_q, line_vld_q;
    logic      loop;
    lb_state_e state;

    assign bnd = !ph_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q       <= 1'b0;
            line_bit_q <= 1'b0;
            line_vld_q <= 1'b0;
        end else begin
            ph_q <= ~ph_q;
            if (bnd) begin
                line_bit_q <= line_data;
                line_vld_q <= line_valid;
            end
        end
    end

    lb_manch_enc u_enc (
        .clk(clk), .rst_n(rst_n), .bnd(bnd), .txd(txd), .tx_en(tx_en),
        .man_o(man), .vld_o(enc_vld)
    );

    lb_manch_dec u_dec (
        .clk(clk), .rst_n(rst_n), .bnd(bnd), .man_i(man), .vld_i(enc_vld),
        .bit_o(dec_bit), .vld_o(dec_vld)
    );

    lb_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .bnd(bnd), .tx_en(tx_en), .col(col),
        .link_fail(link_fail), .jabber(jabber), .enc_vld(enc_vld),
        .state_o(state), .loop_o(loop)
    );

    lb_heartbeat #(.HB_LEN(HB_LEN)) u_hb (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .hb_o(hb_col)
    );

    always_comb begin
        rxd   = loop ? dec_bit : line_bit_q;
        rx_dv = loop ? dec_vld : line_vld_q;
    end

    p_bit_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bnd) |-> ($stable(rxd) && $stable(rx_dv)));
    p_loop_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOOP) |-> (enc_vld || dec_vld));
endmodule

// File: tb/tenbt_loopback_bench.sv
module tenbt_loopback_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HB_LEN     = 12;
    localparam int S_LINKDN = 0, S_IDLE = 1, S_LOOP = 2, S_HOLD = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 0, txd = 0, line_data = 0, line_valid = 0;
    logic col = 0, link_fail = 0, jabber = 0;
    logic rxd, rx_dv, hb_col;

    int n_checks = 0, n_fail = 0, hb_seen = 0;
    bit done = 0;
    int m_state = S_LINKDN;
    logic m_enc_b = 0, m_enc_v = 0, m_dec_b = 0, m_dec_v = 0, m_ln_b = 0, m_ln_v = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tenbt_loopback #(.HB_LEN(HB_LEN)) u_tenbt_loopback (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .txd(txd),
        .line_data(line_data), .line_valid(line_valid), .col(col),
        .link_fail(link_fail), .jabber(jabber),
        .rxd(rxd), .rx_dv(rx_dv), .hb_col(hb_col)
    );

    function automatic int next_state(int s, logic te, logic c, logic lf, logic jb, logic ev);
        if (lf) return S_LINKDN;
        case (s)
            S_LINKDN: return te ? S_HOLD : S_IDLE;
            S_IDLE:   return te ? ((c || jb) ? S_HOLD : S_LOOP) : S_IDLE;
            S_LOOP:   return (c || jb) ? S_HOLD : ((!te && !ev) ? S_IDLE : S_LOOP);
            default:  return te ? S_HOLD : S_IDLE;
        endcase
    endfunction

    function automatic string tag_of(int s);
        case (s)
            S_LOOP:   return "R1";
            S_LINKDN: return "R4";
            S_HOLD:   return "R3/R5";
            default:  return "R6";
        endcase
    endfunction

    task automatic check2(string req, logic [1:0] got, logic [1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: {rxd,rx_dv} got %b expected %b", req, got, exp);
        end
    endtask

    task automatic check_int(string req, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // one bit period; called at a negedge just before a boundary edge
    task automatic step(logic te, logic d, logic ld, logic lv, logic c, logic lf, logic jb);
        logic [1:0] mid;
        tx_en = te; txd = d; line_data = ld; line_valid = lv;
        col = c; link_fail = lf; jabber = jb;
        m_state = next_state(m_state, te, c, lf, jb, m_enc_v);
        m_dec_b = m_enc_b; m_dec_v = m_enc_v;
        m_enc_b = d;       m_enc_v = te;
        m_ln_b  = ld;      m_ln_v  = lv;
        @(posedge clk); @(negedge clk);
        mid = {rxd, rx_dv};
        hb_seen += int'(hb_col);
        @(posedge clk); @(negedge clk);
        hb_seen += int'(hb_col);
        if (m_state == S_LOOP) check2(tag_of(m_state), {rxd, rx_dv}, {m_dec_b, m_dec_v});
        else                   check2(tag_of(m_state), {rxd, rx_dv}, {m_ln_b, m_ln_v});
        check2("R7", {rxd, rx_dv}, mid);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] pat;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check2("R9", {rxd, rx_dv}, 2'b00);
        check_int("R9 hb_col", int'(hb_col), 0);
        rst_n = 1'b1;

        // R4: link fail blocks loopback even while transmitting
        for (int i = 0; i < 4; i++) step(1, i[0], ~i[0], 1, 0, 1, 0);
        step(0, 0, 1, 0, 0, 0, 0);
        repeat (HB_LEN) step(0, 0, 0, 0, 0, 0, 0);

        // R1/R2: clean looped frame, line carries the opposite pattern
        pat = 8'b1011_0010;
        for (int i = 0; i < 8; i++) step(1, pat[i], ~pat[i], 1, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0, 0);
        check2("R2 last bit", {rxd, rx_dv}, {pat[7], 1'b1});
        step(0, 0, 1, 1, 0, 0, 0);
        check2("R2 back to line", {rxd, rx_dv}, 2'b11);

        // R8: heartbeat length after that frame
        hb_seen = 0;
        repeat (HB_LEN) step(0, 0, 0, 0, 0, 0, 0);
        check_int("R8 quiet", int'(hb_col), 0);
        for (int i = 0; i < 4; i++) step(1, i[1], 0, 0, 0, 0, 0);
        hb_seen = 0;
        step(0, 0, 0, 0, 0, 0, 0);
        check_int("R8 rise", int'(hb_col), 1);
        repeat (HB_LEN) step(0, 0, 0, 0, 0, 0, 0);
        check_int("R8 length", hb_seen, HB_LEN);

        // R8 restart: end, resend two bits, end again
        repeat (2) step(1, 1, 0, 0, 0, 0, 0);
        hb_seen = 0;
        step(0, 0, 0, 0, 0, 0, 0);
        repeat (2) step(1, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        repeat (HB_LEN) step(0, 0, 0, 0, 0, 0, 0);
        check_int("R8 restart", hb_seen, 6 + HB_LEN);

        // R3: collision mid-frame, frame continues, loopback stays off
        for (int i = 0; i < 3; i++) step(1, 1, 0, 1, 0, 0, 0);
        step(1, 1, 0, 0, 1, 0, 0);
        check2("R3 cut", {rxd, rx_dv}, 2'b00);
        for (int i = 0; i < 3; i++) step(1, 1, 0, 1, 0, 0, 0);
        check2("R3 held", {rxd, rx_dv}, 2'b01);
        step(0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);

        // R5: jabber mid-frame
        for (int i = 0; i < 3; i++) step(1, 0, 1, 0, 0, 0, 0);
        step(1, 0, 1, 1, 0, 0, 1);
        check2("R5 cut", {rxd, rx_dv}, 2'b11);
        step(1, 0, 1, 0, 0, 0, 0);
        check2("R5 held", {rxd, rx_dv}, 2'b10);
        step(0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);

        // constrained random traffic
        for (int i = 0; i < 1500; i++) begin
            logic te;
            te = ($urandom_range(0, 9) < 7) ? (m_enc_v | ($urandom_range(0, 7) == 0))
                                            : 1'b0;
            step(te, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), ($urandom_range(0, 24) == 0),
                 ($urandom_range(0, 59) == 0), ($urandom_range(0, 39) == 0));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule